// File: doc/BRIEF.md
# First-Word-Fallthrough Synchronous FIFO

This block is a single-clock queue with one write handshake and one read handshake. The oldest stored word is always visible on the read data output, so a consumer can use it in the same cycle that `rd_avail` is high. Asserting `rd_req` in that cycle drops the word and moves the head forward.

Storage is a small ring of registers. It is read combinationally at the read pointer, so it suits distributed flops and not block RAM. The depth may be any value from 1 up, whether or not it is a power of two. Both pointers wrap modulo the depth. `rd_data` always carries the raw word at the read pointer. After the queue drains, that word is the stale contents of the slot that the next write will fill.

A three-state occupancy machine tracks the fill state. In `OCC_EMPTY`, `occupancy` is 0; only the write handshake can be accepted. It goes to `OCC_PARTIAL`, or to `OCC_FULL` when the depth is 1. In `OCC_PARTIAL`, both handshakes can be accepted; it goes to `OCC_EMPTY` or `OCC_FULL` as the count reaches 0 or the depth. In `OCC_FULL`, `occupancy` equals the depth; only the read handshake can be accepted, and it goes back to `OCC_PARTIAL`, or to `OCC_EMPTY` when the depth is 1.

Top module: `fwft_fifo`

## Requirements
- R1: `rd_avail` is high exactly when `occupancy` is nonzero. While it is high, `rd_data` holds the oldest stored word without any strobe, and it stays unchanged until that word is popped.
- R2: A write is accepted in a cycle where `wr_req` and `wr_room` are both high. `wr_room` is high exactly when `occupancy` is below DEPTH.
- R3: A `wr_req` while the queue is full is ignored. `occupancy` does not change from it, and no stored word is overwritten.
- R4: A cycle with `rd_req` and `rd_avail` both high removes the head word, and `rd_data` then shows the next word. A `rd_req` while `rd_avail` is low has no effect.
- R5: `occupancy` rises by one on a cycle with only a write accepted and falls by one on a cycle with only a read accepted. It is unchanged when both are accepted in the same cycle.
- R6: Both pointers wrap to slot 0 after slot DEPTH-1, for any DEPTH including values that are not powers of two.
- R7: With DEPTH 1, popping leaves `rd_data` unchanged until a new write lands.
- R8: Once the queue is empty, `rd_data` shows the slot at the read pointer, which is the slot the next write fills. It may hold an old word.
- R9: A synchronous `rst` clears both pointers and `occupancy`, so the queue reads as empty with room. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | WIDTH | Word to store |
| wr_req | input | 1 | Write request |
| wr_room | output | 1 | Queue can accept a write |
| rd_data | output | WIDTH | Word at the read pointer |
| rd_req | input | 1 | Pop request |
| rd_avail | output | 1 | Queue holds at least one word |
| occupancy | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The bench builds three copies of the block with WIDTH 8 and DEPTH 3, 2 and 1.

DEPTH 3 is not a power of two, so it exercises the compare-and-clear wrap of both pointers. Its table run covers the rejected write when full, the simultaneous push and pop, and the ignored pop when empty. It also checks the stale word that shows after draining at a wrapped pointer.

DEPTH 2 shows the second word after one pop from a full queue, and the first word again once the queue drains. DEPTH 1 pins the read pointer at zero, so popping leaves the output word in place.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_e;
endpackage

// File: rtl/fwft_ptr.sv
module fwft_ptr #(
    parameter int DEPTH = 3,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam bit POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

    generate
        if (POW2) begin : g_natural
            always_ff @(posedge clk) begin
                if (rst)      ptr <= '0;
                else if (adv) ptr <= ptr + 1'b1;
            end
        end else begin : g_compare
            always_ff @(posedge clk) begin
                if (rst)      ptr <= '0;
                else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/fwft_store.sv
module fwft_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 3,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fwft_ctrl.sv
module fwft_ctrl
    import fwft_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_room,
    output logic          rd_avail,
    output logic          push_go,
    output logic          pop_go,
    output logic [LW-1:0] occupancy
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    occ_state_e    state, state_nx;
    logic [LW-1:0] lvl_nx;

    always_comb begin
        wr_room  = (state != OCC_FULL);
        rd_avail = (state != OCC_EMPTY);
        push_go  = wr_req && wr_room;
        pop_go   = rd_req && rd_avail;
    end

    always_comb begin
        unique case ({push_go, pop_go})
            2'b10:   lvl_nx = occupancy + 1'b1;
            2'b01:   lvl_nx = occupancy - 1'b1;
            default: lvl_nx = occupancy;
        endcase
        if (lvl_nx == '0)            state_nx = OCC_EMPTY;
        else if (lvl_nx == FULL_LVL) state_nx = OCC_FULL;
        else                         state_nx = OCC_PARTIAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= OCC_EMPTY;
            occupancy <= '0;
        end else begin
            state     <= state_nx;
            occupancy <= lvl_nx;
        end
    end
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 3,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_req,
    output logic             wr_room,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_req,
    output logic             rd_avail,
    output logic [LW-1:0]    occupancy
);
    logic          push_go, pop_go;
    logic [PW-1:0] wptr, rptr;

    fwft_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
        .wr_room(wr_room), .rd_avail(rd_avail),
        .push_go(push_go), .pop_go(pop_go), .occupancy(occupancy)
    );

    fwft_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(clk), .rst(rst), .adv(push_go), .ptr(wptr)
    );

    fwft_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk(clk), .rst(rst), .adv(pop_go), .ptr(rptr)
    );

    fwft_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(push_go), .waddr(wptr), .wdata(wr_data),
        .raddr(rptr), .rdata(rd_data)
    );
endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 3,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_req,
    input logic             wr_room,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_req,
    input logic             rd_avail,
    input logic [LW-1:0]    occupancy
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    AST_AVAIL_LEVEL: assert property (@(posedge clk) disable iff (rst)
        rd_avail == (occupancy != '0)); // R1
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_avail && !rd_req) |=> $stable(rd_data)); // R1
    AST_ROOM_LEVEL: assert property (@(posedge clk) disable iff (rst)
        wr_room == (occupancy < FULL_LVL)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occupancy <= FULL_LVL); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_room && !(rd_req && rd_avail)) |=> $stable(occupancy)); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (!rd_avail && !wr_req) |=> (occupancy == '0)); // R4
    AST_LEVEL_UP: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_room && !(rd_req && rd_avail)) |=> (occupancy == $past(occupancy) + 1'b1)); // R5
    AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_avail && !(wr_req && wr_room)) |=> (occupancy == $past(occupancy) - 1'b1)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (occupancy == '0 && !rd_avail && wr_room)); // R9

    generate
        if (DEPTH == 1) begin : g_single
            AST_SINGLE_POP: assert property (@(posedge clk) disable iff (rst)
                (rd_avail && rd_req && !wr_req) |=> $stable(rd_data)); // R7
        end
    endgenerate
endmodule

bind fwft_fifo fwft_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_room(wr_room),
    .rd_data(rd_data), .rd_req(rd_req), .rd_avail(rd_avail),
    .occupancy(occupancy)
);

// File: tb/fwft_fifo_bench.sv
module fwft_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       rd;
        logic       avail;
        logic       room;
        logic [1:0] lvl;
        logic [7:0] data;
    } vec_t;

    // DEPTH 3 sequence; expected outputs are those seen after the clock edge
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h11, 1'b0, 1'b1, 1'b1, 2'd1, 8'h11},  // R2 first write shows at once
        '{1'b1, 8'h22, 1'b0, 1'b1, 1'b1, 2'd2, 8'h11},  // R1 head stays
        '{1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 2'd3, 8'h11},  // R2 full, no room
        '{1'b1, 8'h44, 1'b0, 1'b1, 1'b0, 2'd3, 8'h11},  // R3 write when full ignored
        '{1'b1, 8'h55, 1'b1, 1'b1, 1'b1, 2'd2, 8'h22},  // R4 pop when full, push rejected
        '{1'b1, 8'h66, 1'b1, 1'b1, 1'b1, 2'd2, 8'h33},  // R5 push and pop, level kept
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd1, 8'h66},  // R6 read pointer wraps to 0
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'd0, 8'h22},  // R8 drained, stale slot 1
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'd0, 8'h22},  // R4 pop when empty ignored
        '{1'b1, 8'h77, 1'b1, 1'b1, 1'b1, 2'd1, 8'h77},  // R4 only the write taken
        '{1'b1, 8'h88, 1'b0, 1'b1, 1'b1, 2'd2, 8'h77},  // R6 write pointer wraps
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd1, 8'h88},  // R4 next word
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'd0, 8'h66}   // R8 stale slot 0 after wrap
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   errors = 0;

    logic [7:0] a_wd = '0, b_wd = '0, c_wd = '0;
    logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0, c_wr = 0, c_rd = 0;
    logic a_room, a_avail, b_room, b_avail, c_room, c_avail;
    logic [7:0] a_rdata, b_rdata, c_rdata;
    logic [1:0] a_lvl, b_lvl;
    logic [0:0] c_lvl;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fwft_fifo #(.WIDTH(8), .DEPTH(3)) u_fwft_fifo (
        .clk(clk), .rst(rst), .wr_data(a_wd), .wr_req(a_wr), .wr_room(a_room),
        .rd_data(a_rdata), .rd_req(a_rd), .rd_avail(a_avail), .occupancy(a_lvl)
    );
    fwft_fifo #(.WIDTH(8), .DEPTH(2)) u_fwft_fifo_d2 (
        .clk(clk), .rst(rst), .wr_data(b_wd), .wr_req(b_wr), .wr_room(b_room),
        .rd_data(b_rdata), .rd_req(b_rd), .rd_avail(b_avail), .occupancy(b_lvl)
    );
    fwft_fifo #(.WIDTH(8), .DEPTH(1)) u_fwft_fifo_d1 (
        .clk(clk), .rst(rst), .wr_data(c_wd), .wr_req(c_wr), .wr_room(c_room),
        .rd_data(c_rdata), .rd_req(c_rd), .rd_avail(c_avail), .occupancy(c_lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        // R9 reset state on every copy
        chk("R9 d3 level", int'(a_lvl), 0);
        chk("R9 d3 avail", int'(a_avail), 0);
        chk("R9 d3 room", int'(a_room), 1);
        chk("R9 d1 level", int'(c_lvl), 0);
        chk("R9 d1 room", int'(c_room), 1);

        // Table run on DEPTH 3
        for (int i = 0; i < NV; i++) begin
            a_wr = TBL[i].wr;
            a_wd = TBL[i].wd;
            a_rd = TBL[i].rd;
            step();
            chk($sformatf("R1 vec%0d avail", i), int'(a_avail), int'(TBL[i].avail));
            chk($sformatf("R2 vec%0d room", i), int'(a_room), int'(TBL[i].room));
            chk($sformatf("R5 vec%0d level", i), int'(a_lvl), int'(TBL[i].lvl));
            chk($sformatf("R8 vec%0d data", i), int'(a_rdata), int'(TBL[i].data));
        end
        a_wr = 0;
        a_rd = 0;

        // DEPTH 2: second word after one pop, first word back once drained
        b_wr = 1; b_wd = 8'hA1; step();
        b_wd = 8'hB2; step();
        b_wr = 0;
        chk("R2 d2 full room", int'(b_room), 0);
        chk("R1 d2 head", int'(b_rdata), 8'hA1);
        b_rd = 1; step();
        chk("R4 d2 second word", int'(b_rdata), 8'hB2);
        chk("R5 d2 level", int'(b_lvl), 1);
        step();
        b_rd = 0;
        chk("R8 d2 stale first word", int'(b_rdata), 8'hA1);
        chk("R4 d2 empty", int'(b_avail), 0);

        // DEPTH 1: pointer stays at zero
        c_wr = 1; c_wd = 8'hC3; step();
        chk("R1 d1 word", int'(c_rdata), 8'hC3);
        chk("R2 d1 room", int'(c_room), 0);
        c_wd = 8'hD4; step();
        chk("R3 d1 no overwrite", int'(c_rdata), 8'hC3);
        chk("R3 d1 level", int'(c_lvl), 1);
        c_wr = 0; c_rd = 1; step();
        c_rd = 0;
        chk("R7 d1 pop keeps word", int'(c_rdata), 8'hC3);
        chk("R7 d1 empty", int'(c_avail), 0);
        c_wr = 1; c_wd = 8'hE5; step();
        c_wr = 0;
        chk("R7 d1 new write shows", int'(c_rdata), 8'hE5);

        // R9 reset from a non-empty state
        a_wr = 1; a_wd = 8'h99; step();
        a_wr = 0;
        chk("R9 d3 pre-reset level", int'(a_lvl), 1);
        rst = 1; step();
        rst = 0;
        chk("R9 d3 level cleared", int'(a_lvl), 0);
        chk("R9 d3 avail cleared", int'(a_avail), 0);
        chk("R9 d1 level cleared", int'(c_lvl), 0);
        chk("R9 d1 room back", int'(c_room), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule